// File: doc/BRIEF.md
# MSI Coherence Directory

This block is the home node of an MSI coherence scheme for a handful of private caches. For every line it keeps a line state, a bit vector of sharers and the ID of the one owner. It also keeps a small array that backs each line's data. The line states are **Invalid (I)**, **Shared (S)**, **Modified (M)** and **Shared-awaiting-data (S-D)**. Caches send GetS, GetM, PutS and PutM requests, each tagged with the sender's ID. The directory answers with one message on one of four outgoing channels:

- a data reply that carries an ack count;
- an invalidation to each sharer;
- a forwarded GetS or GetM sent to the current owner;
- a Put-Ack.

A former owner's data comes back on a separate input. That data is written into the array and closes the S-D window.

The controller has two states: **IDLE** and **WALK**. In IDLE it accepts one request per cycle. A GetM that hits a line in S with other sharers moves it to WALK. In WALK it sends one invalidation per cycle, in ascending cache-ID order, and holds the request port off until the last one has gone out. Every output is registered, so a message appears in the cycle after the request is accepted. Only one channel is valid in any cycle.

Top module: `msi_dir`

## Requirements
- R1: After reset every line is in I with no sharers and no owner, line i of the array holds the value i, no output channel is valid and req_ready is high.
- R2: In I, GetS replies with data (acks 0) and the line goes to S with the requester as sharer. GetM replies with data (acks 0) and the line goes to M with the requester as owner.
- R3: In S, GetS replies with data (acks 0) and adds the requester. GetM replies with data whose acks equal the number of sharers other than the requester, clears the sharers and moves to M with the requester as owner.
- R4: After that data reply, one invalidation per cycle goes to each other sharer in ascending ID order, starting the next cycle and naming the requester. req_ready stays low until the last one is issued. At most one channel is valid per cycle.
- R5: In S, PutS removes the requester and returns a Put-Ack. The line falls to I once no sharer is left.
- R6: In M, GetS sends a forwarded GetS (fwd_getm=0) to the owner naming the requester, makes requester and old owner the sharers, clears the owner and enters S-D. GetS or GetM to an S-D line holds req_ready low.
- R7: In M, GetM sends a forwarded GetM (fwd_getm=1) to the old owner and makes the requester the new owner.
- R8: A PutM from the owner of an M line writes its data to the array, returns a Put-Ack and moves the line to I.
- R9: A PutM from a non-owner returns only a Put-Ack, never writes the array, and removes the sender from the sharers in S or S-D.
- R10: In S-D, PutS and PutM remove the sender and are acknowledged. Owner data writes the array and moves the line to S, or to I if no sharer remains.
- R11: A PutS or PutM to a line in I, and a PutS to a line in M, only return a Put-Ack.
- R12: Owner data for a line not in S-D has no effect. While own_valid is high, req_ready is low.

Request kinds on req_kind: 0 GetS, 1 GetM, 2 PutS, 3 PutM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_kind | input | 2 | 0 GetS, 1 GetM, 2 PutS, 3 PutM |
| req_src | input | ID_W | Requesting cache ID |
| req_addr | input | ADDR_W | Line index |
| req_data | input | DATA_W | PutM write-back data |
| own_valid | input | 1 | Former-owner data arrives |
| own_addr | input | ADDR_W | Line of owner data |
| own_data | input | DATA_W | Owner data value |
| dat_valid | output | 1 | Data reply valid |
| dat_dst | output | ID_W | Data reply destination |
| dat_addr | output | ADDR_W | Data reply line |
| dat_data | output | DATA_W | Data reply value |
| dat_acks | output | CNT_W | Number of invalidation acks the requester must collect |
| inv_valid | output | 1 | Invalidation valid |
| inv_dst | output | ID_W | Sharer being invalidated |
| inv_addr | output | ADDR_W | Invalidated line |
| inv_req | output | ID_W | Cache that should receive the ack |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_getm | output | 1 | 1 forwarded GetM, 0 forwarded GetS |
| fwd_dst | output | ID_W | Owner receiving the forward |
| fwd_addr | output | ADDR_W | Forwarded line |
| fwd_req | output | ID_W | Original requester |
| pack_valid | output | 1 | Put-Ack valid |
| pack_dst | output | ID_W | Put-Ack destination |
| pack_addr | output | ADDR_W | Acknowledged line |

## Verification
The bench targets several corner cases; each lists the faulty behaviour it would expose.

- **Ack count on a GetM from S when the requester is already a sharer.** A design that forgets to mask the requester out replies with too many acks and invalidates the requester itself.
- **S-D window.** If the stall is missing, a GetS slips through and is served stale data. If the owner-data path is wrong, the next reply shows the old array value or never leaves S-D.
- **Owner versus non-owner PutM.** A design that writes on any PutM corrupts the line with a stale value. A design that drops the non-owner from the sharers too late sends it an extra invalidation later.
- **Last-sharer exits.** Leaving S, or leaving S-D without sharers, must reach I, which later ack counts and forward targets expose.
- **Owner data for a line not in S-D.** It must leave the array unchanged, and a later read shows the original value.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;

    typedef enum logic [1:0] {
        LN_I  = 2'd0,
        LN_S  = 2'd1,
        LN_M  = 2'd2,
        LN_SD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        RQ_GETS = 2'd0,
        RQ_GETM = 2'd1,
        RQ_PUTS = 2'd2,
        RQ_PUTM = 2'd3
    } req_kind_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_WALK = 1'b1
    } ctl_st_e;

endpackage

// File: rtl/msi_dir_popcnt.sv
module msi_dir_popcnt #(
    parameter int N     = 4,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CNT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/msi_dir_walker.sv
module msi_dir_walker #(
    parameter int N    = 4,
    parameter int ID_W = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [N-1:0]    load_mask,
    output logic            busy,
    output logic            last,
    output logic [ID_W-1:0] pick
);
    logic [N-1:0] mask_q;
    logic [N-1:0] rest;

    assign rest = mask_q & (mask_q - N'(1));
    assign busy = |mask_q;
    assign last = busy && (rest == '0);

    // lowest set bit wins: scan downward so the last hit is the smallest index
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_q[i]) pick = ID_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (load)    mask_q <= load_mask;
        else if (busy)    mask_q <= rest;
    end
endmodule

// File: rtl/msi_dir.sv
module msi_dir
    import msi_dir_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int NUM_LINES  = 4,
    parameter int DATA_W     = 8,
    localparam int ID_W      = $clog2(NUM_CACHES),
    localparam int ADDR_W    = $clog2(NUM_LINES),
    localparam int CNT_W     = $clog2(NUM_CACHES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ID_W-1:0]   req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              own_valid,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] own_data,
    output logic              dat_valid,
    output logic [ID_W-1:0]   dat_dst,
    output logic [ADDR_W-1:0] dat_addr,
    output logic [DATA_W-1:0] dat_data,
    output logic [CNT_W-1:0]  dat_acks,
    output logic              inv_valid,
    output logic [ID_W-1:0]   inv_dst,
    output logic [ADDR_W-1:0] inv_addr,
    output logic [ID_W-1:0]   inv_req,
    output logic              fwd_valid,
    output logic              fwd_getm,
    output logic [ID_W-1:0]   fwd_dst,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [ID_W-1:0]   fwd_req,
    output logic              pack_valid,
    output logic [ID_W-1:0]   pack_dst,
    output logic [ADDR_W-1:0] pack_addr
);
    // per-line directory tables and backing array
    line_st_e              ln_st  [NUM_LINES];
    logic [NUM_CACHES-1:0] ln_sh  [NUM_LINES];
    logic [ID_W-1:0]       ln_own [NUM_LINES];
    logic [DATA_W-1:0]     ln_mem [NUM_LINES];

    ctl_st_e ctl_q, ctl_d;

    req_kind_e             kind;
    line_st_e              sel_st;
    logic [NUM_CACHES-1:0] sel_sh, src_bit, own_bit, others;
    logic [ID_W-1:0]       sel_own;
    logic [DATA_W-1:0]     sel_mem;
    logic [CNT_W-1:0]      others_cnt;
    logic                  accept, own_hit;

    line_st_e              nx_st;
    logic [NUM_CACHES-1:0] nx_sh;
    logic [ID_W-1:0]       nx_own;
    logic                  mem_we, send_dat, send_fwd, fwd_m, send_pack, walk_load;
    logic [CNT_W-1:0]      acks_n;

    logic                  walk_busy, walk_last;
    logic [ID_W-1:0]       walk_pick;
    logic [ADDR_W-1:0]     walk_addr_q;
    logic [ID_W-1:0]       walk_req_q;

    assign kind    = req_kind_e'(req_kind);
    assign sel_st  = ln_st[req_addr];
    assign sel_sh  = ln_sh[req_addr];
    assign sel_own = ln_own[req_addr];
    assign sel_mem = ln_mem[req_addr];
    assign src_bit = NUM_CACHES'(1) << req_src;
    assign own_bit = NUM_CACHES'(1) << sel_own;
    assign others  = sel_sh & ~src_bit;

    assign req_ready = !own_valid && (ctl_q == CTL_IDLE) &&
                       !((sel_st == LN_SD) && ((kind == RQ_GETS) || (kind == RQ_GETM)));
    assign accept    = req_valid && req_ready;
    assign own_hit   = own_valid && (ln_st[own_addr] == LN_SD);

    msi_dir_popcnt #(.N(NUM_CACHES), .CNT_W(CNT_W)) u_cnt (
        .vec (others),
        .cnt (others_cnt)
    );

    msi_dir_walker #(.N(NUM_CACHES), .ID_W(ID_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept && walk_load),
        .load_mask (others),
        .busy      (walk_busy),
        .last      (walk_last),
        .pick      (walk_pick)
    );

    // per-request line transition and message selection
    always_comb begin
        nx_st     = sel_st;
        nx_sh     = sel_sh;
        nx_own    = sel_own;
        mem_we    = 1'b0;
        send_dat  = 1'b0;
        send_fwd  = 1'b0;
        fwd_m     = 1'b0;
        send_pack = 1'b0;
        walk_load = 1'b0;
        acks_n    = '0;
        unique case (sel_st)
            LN_I: begin
                unique case (kind)
                    RQ_GETS: begin send_dat = 1'b1; nx_sh = src_bit; nx_st = LN_S; end
                    RQ_GETM: begin send_dat = 1'b1; nx_own = req_src; nx_st = LN_M; end
                    RQ_PUTS, RQ_PUTM: send_pack = 1'b1;
                endcase
            end
            LN_S: begin
                unique case (kind)
                    RQ_GETS: begin send_dat = 1'b1; nx_sh = sel_sh | src_bit; end
                    RQ_GETM: begin
                        send_dat  = 1'b1;
                        acks_n    = others_cnt;
                        walk_load = |others;
                        nx_sh     = '0;
                        nx_own    = req_src;
                        nx_st     = LN_M;
                    end
                    RQ_PUTS, RQ_PUTM: begin
                        send_pack = 1'b1;
                        nx_sh     = others;
                        if (others == '0) nx_st = LN_I;
                    end
                endcase
            end
            LN_M: begin
                unique case (kind)
                    RQ_GETS: begin
                        send_fwd = 1'b1;
                        nx_sh    = src_bit | own_bit;
                        nx_own   = '0;
                        nx_st    = LN_SD;
                    end
                    RQ_GETM: begin send_fwd = 1'b1; fwd_m = 1'b1; nx_own = req_src; end
                    RQ_PUTS: send_pack = 1'b1;
                    RQ_PUTM: begin
                        send_pack = 1'b1;
                        if (req_src == sel_own) begin
                            mem_we = 1'b1;
                            nx_own = '0;
                            nx_st  = LN_I;
                        end
                    end
                endcase
            end
            LN_SD: begin
                if ((kind == RQ_PUTS) || (kind == RQ_PUTM)) begin
                    send_pack = 1'b1;
                    nx_sh     = others;
                end
            end
        endcase
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            CTL_IDLE: if (accept && walk_load) ctl_d = CTL_WALK;
            CTL_WALK: if (walk_last)           ctl_d = CTL_IDLE;
        endcase
    end

    // state register: controller state and directory tables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= CTL_IDLE;
            walk_addr_q <= '0;
            walk_req_q  <= '0;
            for (int i = 0; i < NUM_LINES; i++) begin
                ln_st[i]  <= LN_I;
                ln_sh[i]  <= '0;
                ln_own[i] <= '0;
                ln_mem[i] <= DATA_W'(i);
            end
        end else begin
            ctl_q <= ctl_d;
            if (accept) begin
                ln_st[req_addr]  <= nx_st;
                ln_sh[req_addr]  <= nx_sh;
                ln_own[req_addr] <= nx_own;
                if (mem_we) ln_mem[req_addr] <= req_data;
                if (walk_load) begin
                    walk_addr_q <= req_addr;
                    walk_req_q  <= req_src;
                end
            end else if (own_hit) begin
                ln_mem[own_addr] <= own_data;
                ln_st[own_addr]  <= (ln_sh[own_addr] != '0) ? LN_S : LN_I;
            end
        end
    end

    // output register: one message per cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_valid  <= 1'b0; dat_dst  <= '0; dat_addr <= '0; dat_data <= '0; dat_acks <= '0;
            inv_valid  <= 1'b0; inv_dst  <= '0; inv_addr <= '0; inv_req  <= '0;
            fwd_valid  <= 1'b0; fwd_getm <= 1'b0; fwd_dst <= '0; fwd_addr <= '0; fwd_req <= '0;
            pack_valid <= 1'b0; pack_dst <= '0; pack_addr <= '0;
        end else begin
            dat_valid  <= accept && send_dat;
            dat_dst    <= req_src;
            dat_addr   <= req_addr;
            dat_data   <= sel_mem;
            dat_acks   <= acks_n;
            inv_valid  <= walk_busy;
            inv_dst    <= walk_pick;
            inv_addr   <= walk_addr_q;
            inv_req    <= walk_req_q;
            fwd_valid  <= accept && send_fwd;
            fwd_getm   <= fwd_m;
            fwd_dst    <= sel_own;
            fwd_addr   <= req_addr;
            fwd_req    <= req_src;
            pack_valid <= accept && send_pack;
            pack_dst   <= req_src;
            pack_addr  <= req_addr;
        end
    end
endmodule

// File: rtl/msi_dir_chk.sv
module msi_dir_chk #(
    parameter int NUM_CACHES = 4,
    parameter int ID_W       = $clog2(NUM_CACHES),
    parameter int CNT_W      = $clog2(NUM_CACHES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             own_valid,
    input logic             dat_valid,
    input logic [CNT_W-1:0] dat_acks,
    input logic             inv_valid,
    input logic [ID_W-1:0]  inv_dst,
    input logic             fwd_valid,
    input logic             pack_valid
);
    assert_single_msg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dat_valid, inv_valid, fwd_valid, pack_valid}) <= 1);

    assert_own_stalls_R12: assert property (@(posedge clk) disable iff (!rst_n)
        own_valid |-> !req_ready);

    assert_inv_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && $past(inv_valid)) |-> (inv_dst > $past(inv_dst)));

    assert_acks_lead_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_acks != '0) |=> inv_valid);

    assert_walk_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_acks != '0) |-> !req_ready);

    assert_inv_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !$past(inv_valid)) |-> ($past(dat_valid) && $past(dat_acks) != '0));
endmodule

bind msi_dir msi_dir_chk #(.NUM_CACHES(NUM_CACHES), .ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .own_valid  (own_valid),
    .dat_valid  (dat_valid),
    .dat_acks   (dat_acks),
    .inv_valid  (inv_valid),
    .inv_dst    (inv_dst),
    .fwd_valid  (fwd_valid),
    .pack_valid (pack_valid)
);

// File: tb/tb_msi_dir.sv
module tb_msi_dir;
    localparam int NC = 4;
    localparam int NL = 4;
    localparam int DW = 8;
    localparam int IW = $clog2(NC);
    localparam int AW = $clog2(NL);
    localparam int CW = $clog2(NC + 1);

    localparam logic [1:0] GETS = 2'd0, GETM = 2'd1, PUTS = 2'd2, PUTM = 2'd3;
    localparam logic [2:0] K_DAT = 3'd0, K_INV = 3'd1, K_FWS = 3'd2, K_FWM = 3'd3, K_ACK = 3'd4;

    typedef struct packed {
        logic [2:0]    kind;
        logic [IW-1:0] dst;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [IW:0]   aux;
    } msg_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, own_valid = 1'b0;
    logic [1:0] req_kind = '0;
    logic [IW-1:0] req_src = '0;
    logic [AW-1:0] req_addr = '0, own_addr = '0;
    logic [DW-1:0] req_data = '0, own_data = '0;
    logic req_ready;
    logic dat_valid, inv_valid, fwd_valid, fwd_getm, pack_valid;
    logic [IW-1:0] dat_dst, inv_dst, inv_req, fwd_dst, fwd_req, pack_dst;
    logic [AW-1:0] dat_addr, inv_addr, fwd_addr, pack_addr;
    logic [DW-1:0] dat_data;
    logic [CW-1:0] dat_acks;

    int checks = 0, fails = 0;
    msg_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    msi_dir #(.NUM_CACHES(NC), .NUM_LINES(NL), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .own_valid(own_valid), .own_addr(own_addr), .own_data(own_data),
        .dat_valid(dat_valid), .dat_dst(dat_dst), .dat_addr(dat_addr),
        .dat_data(dat_data), .dat_acks(dat_acks),
        .inv_valid(inv_valid), .inv_dst(inv_dst), .inv_addr(inv_addr), .inv_req(inv_req),
        .fwd_valid(fwd_valid), .fwd_getm(fwd_getm), .fwd_dst(fwd_dst),
        .fwd_addr(fwd_addr), .fwd_req(fwd_req),
        .pack_valid(pack_valid), .pack_dst(pack_dst), .pack_addr(pack_addr)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_msg(input logic [2:0] k, input int dst, input int addr,
                              input int data, input int aux, input string tag);
        msg_t m;
        m.kind = k; m.dst = IW'(dst); m.addr = AW'(addr);
        m.data = DW'(data); m.aux = (IW+1)'(aux);
        exp_q.push_back(m);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [1:0] k, input int src, input int addr, input int d);
        req_valid = 1'b1; req_kind = k; req_src = IW'(src);
        req_addr = AW'(addr); req_data = DW'(d);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic own(input int addr, input int d);
        own_valid = 1'b1; own_addr = AW'(addr); own_data = DW'(d);
        @(posedge clk); @(negedge clk);
        own_valid = 1'b0;
    endtask

    // monitor: compare each produced message with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && (dat_valid || inv_valid || fwd_valid || pack_valid)) begin
            msg_t obs;
            obs = '0;
            if (dat_valid) begin
                obs.kind = K_DAT; obs.dst = dat_dst; obs.addr = dat_addr;
                obs.data = dat_data; obs.aux = (IW+1)'(dat_acks);
            end else if (inv_valid) begin
                obs.kind = K_INV; obs.dst = inv_dst; obs.addr = inv_addr;
                obs.aux = (IW+1)'(inv_req);
            end else if (fwd_valid) begin
                obs.kind = fwd_getm ? K_FWM : K_FWS; obs.dst = fwd_dst;
                obs.addr = fwd_addr; obs.aux = (IW+1)'(fwd_req);
            end else begin
                obs.kind = K_ACK; obs.dst = pack_dst; obs.addr = pack_addr;
            end
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected message", longint'(obs), 0);
            end else begin
                msg_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(obs == e, t, longint'(obs), longint'(e));
            end
        end
    end

    initial begin
        #(8 * 20000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(!(dat_valid || inv_valid || fwd_valid || pack_valid), "R1 outputs idle",
              {dat_valid, inv_valid, fwd_valid, pack_valid}, 0);
        check(req_ready, "R1 ready after reset", req_ready, 1);
        @(negedge clk);

        // line 0: I -> S, grow sharers, R1 init value 0
        expect_msg(K_DAT, 1, 0, 0, 0, "R2 GetS from I");   send(GETS, 1, 0, 0);
        expect_msg(K_DAT, 3, 0, 0, 0, "R3 GetS in S");     send(GETS, 3, 0, 0);
        expect_msg(K_DAT, 0, 0, 0, 0, "R3 GetS in S");     send(GETS, 0, 0, 0);
        // GetM by sharer 3: acks = 2, inv to 0 then 1
        expect_msg(K_DAT, 3, 0, 0, 2, "R3 GetM ack count");
        expect_msg(K_INV, 0, 0, 0, 3, "R4 first inv");
        expect_msg(K_INV, 1, 0, 0, 3, "R4 second inv");
        send(GETM, 3, 0, 0);
        #1; check(!req_ready, "R4 held during walk", req_ready, 0);
        @(negedge clk);
        // M owner 3 -> GetM from 2
        expect_msg(K_FWM, 3, 0, 0, 2, "R7 fwd GetM");      send(GETM, 2, 0, 0);
        expect_msg(K_FWS, 2, 0, 0, 1, "R7 new owner gets fwd / R6 fwd GetS");
        send(GETS, 1, 0, 0);
        // S-D stall
        req_valid = 1'b1; req_kind = GETS; req_src = 0; req_addr = 0; #1;
        check(!req_ready, "R6 GetS stalled in S-D", req_ready, 0);
        req_kind = GETM; #1;
        check(!req_ready, "R6 GetM stalled in S-D", req_ready, 0);
        @(posedge clk); @(negedge clk); req_valid = 1'b0;
        expect_msg(K_ACK, 1, 0, 0, 0, "R10 PutS in S-D");  send(PUTS, 1, 0, 0);
        own(0, 8'h5A);
        expect_msg(K_DAT, 0, 0, 8'h5A, 1, "R10 data written, S with sharer 2");
        expect_msg(K_INV, 2, 0, 0, 0, "R10 remaining sharer invalidated");
        send(GETM, 0, 0, 0);
        // M owner 0
        expect_msg(K_ACK, 1, 0, 0, 0, "R9 non-owner PutM"); send(PUTM, 1, 0, 8'h77);
        expect_msg(K_ACK, 2, 0, 0, 0, "R11 PutS in M");     send(PUTS, 2, 0, 0);
        expect_msg(K_ACK, 0, 0, 0, 0, "R8 owner PutM");     send(PUTM, 0, 0, 8'h33);
        expect_msg(K_DAT, 2, 0, 8'h33, 0, "R8 write-back and I, R9 no write");
        send(GETS, 2, 0, 0);

        // line 1: Puts in I, ignored owner data
        expect_msg(K_ACK, 0, 1, 0, 0, "R11 PutS in I");     send(PUTS, 0, 1, 0);
        expect_msg(K_ACK, 1, 1, 0, 0, "R11 PutM in I");     send(PUTM, 1, 1, 8'h99);
        own(1, 8'hEE);
        expect_msg(K_DAT, 0, 1, 1, 0, "R12 owner data ignored / R11 no write");
        send(GETS, 0, 1, 0);
        expect_msg(K_DAT, 1, 1, 1, 0, "R3 GetS in S");      send(GETS, 1, 1, 0);
        expect_msg(K_ACK, 1, 1, 0, 0, "R5 PutS in S");      send(PUTS, 1, 1, 0);
        expect_msg(K_DAT, 2, 1, 1, 1, "R5 sharer removed");
        expect_msg(K_INV, 0, 1, 0, 2, "R5 only sharer 0 invalidated");
        send(GETM, 2, 1, 0);

        // line 2: last sharer leaves
        expect_msg(K_DAT, 3, 2, 2, 0, "R2 GetS from I");    send(GETS, 3, 2, 0);
        expect_msg(K_ACK, 3, 2, 0, 0, "R5 last PutS");      send(PUTS, 3, 2, 0);
        expect_msg(K_DAT, 1, 2, 2, 0, "R5 back in I / R2 GetM from I");
        send(GETM, 1, 2, 0);
        expect_msg(K_FWS, 1, 2, 0, 0, "R2 owner recorded / R6 fwd GetS");
        send(GETS, 0, 2, 0);

        // own_valid blocks requests
        own_valid = 1'b1; own_addr = 3; own_data = 8'hC3;
        req_valid = 1'b1; req_kind = GETS; req_src = 0; req_addr = 3; #1;
        check(!req_ready, "R12 request blocked by owner data", req_ready, 0);
        @(posedge clk); @(negedge clk);
        own_valid = 1'b0; req_valid = 1'b0;
        expect_msg(K_DAT, 0, 3, 3, 0, "R12 owner data to I line ignored");
        send(GETS, 0, 3, 0);
        expect_msg(K_DAT, 1, 3, 3, 0, "R3 GetS in S");      send(GETS, 1, 3, 0);
        expect_msg(K_ACK, 1, 3, 0, 0, "R9 non-owner PutM in S"); send(PUTM, 1, 3, 8'h44);
        expect_msg(K_DAT, 2, 3, 3, 1, "R9 sender removed, no write");
        expect_msg(K_INV, 0, 3, 0, 2, "R9 only sharer 0 invalidated");
        send(GETM, 2, 3, 0);

        // line 2 in S-D with sharers {0,1}: all leave, then data -> I
        expect_msg(K_ACK, 0, 2, 0, 0, "R10 PutS in S-D");   send(PUTS, 0, 2, 0);
        expect_msg(K_ACK, 1, 2, 0, 0, "R10 PutM in S-D");   send(PUTM, 1, 2, 8'h55);
        own(2, 8'h66);
        expect_msg(K_DAT, 3, 2, 8'h66, 0, "R10 data written, no sharers -> I");
        send(GETM, 3, 2, 0);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "all expected messages seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule